// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a small byte-organised serial EEPROM on a two-wire bus. It holds 256 bytes. The clock and data lines reach it as plain inputs that the system clock oversamples. It answers the bus master by enabling a pull-down on the data line. A three-bit strap input picks which of up to eight identical slaves on the bus responds.

A transfer opens with a START condition and a device select byte. A write then carries a word address and up to sixteen data bytes. The data bytes collect in a page buffer, and the array is updated only when the master sends STOP. After the update a self-timed write window runs, and the busy output stays high for a parameterised number of clocks. While it is high, the slave ignores its own select byte.

Reads come in three forms:
- A current-address read starts at the internal pointer.
- A selective read writes an address without data, issues a repeated START and then reads.
- A sequential read continues for as long as the master acknowledges, and wraps from the top of the array back to zero.

A write-protect input freezes the whole array.

Top module: `seeprom_slave`

## Requirements
- R1: After reset, busy_o is low, the SDA pull-down is off, every array byte reads FFh and the internal pointer is 00h.
- R2: The select byte is 1010b in bits 7..4, the strap value in bits 3..1 and read (1) / write (0) in bit 0. The slave acknowledges it only on a full match. On any mismatch it leaves SDA released for the rest of the transfer, until the next START.
- R3: A write of the select byte, one address byte and one data byte, followed by STOP, stores that data byte at that address.
- R4: In a multi-byte write, the byte position advances through address bits 3..0 and wraps inside the 16-byte page, leaving bits 7..4 fixed. A byte past the sixteenth overwrites the earlier byte at the same position.
- R5: Buffered write data reaches the array only at STOP. A repeated START discards it, and no write window follows.
- R6: After a STOP that commits data, busy_o stays high for exactly WR_CYCLES clock cycles. While busy_o is high, the slave does not acknowledge its select byte.
- R7: With wp_i high, write data bytes are still acknowledged. The array keeps its contents and busy_o stays low.
- R8: A selective read (select-write, address, repeated START, select-read) returns the byte at the given address.
- R9: A sequential read continues while the master acknowledges, stepping the pointer by one and wrapping from FFh to 00h.
- R10: After a read ends with a master NACK and STOP, a current-address read returns the byte that follows the last byte sent.
- R11: The slave changes its SDA pull-down only while SCL is low, except for releasing it on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND, includes own pull-down) |
| sda_pull_o | output | 1 | 1 enables the pull-down on the data line |
| strap_i | input | 3 | Hardware-strapped slave address bits |
| wp_i | input | 1 | 1 makes the whole array read-only |
| busy_o | output | 1 | High during the self-timed write window |

## Verification
The bench targets the following corner cases, and the failure each one would expose:
- **Mid-page write start.** A page write that starts in the middle of a page and runs past sixteen bytes shows whether a design carries into address bits 7..4 or drops the overwrite.
- **Sequential read through FFh.** This exposes a pointer that saturates, or that stops at a page edge.
- **Current-address read after a NACKed read.** This catches a pointer that is off by one.
- **Write abandoned by a repeated START.** A design that commits on any bus event would change the array and raise busy_o here.
- **Select byte during the write window, and select bytes with a wrong strap or type.** A design that answers them would corrupt transfers aimed at other slaves.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } link_st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_ADDR,
    PH_DATA
  } rx_phase_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/seeprom_busmon.sv
module seeprom_busmon
  import seeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o,
  output logic    scl_lvl_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] scl_sh;
  logic [SH_W-1:0] sda_sh;
  logic [SH_W-1:0] scl_sh_n;
  logic [SH_W-1:0] sda_sh_n;
  logic            scl_s, scl_q, sda_s, sda_q;

  always_comb begin
    scl_sh_n = {scl_sh[SH_W-2:0], scl_i};
    sda_sh_n = {sda_sh[SH_W-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_q = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_q = sda_sh[SYNC_STAGES];

  always_comb begin
    ev_o.scl_rise = scl_s & ~scl_q;
    ev_o.scl_fall = ~scl_s & scl_q;
    ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    ev_o.sda      = sda_s;
  end

  assign scl_lvl_o = scl_s;

endmodule

// File: rtl/seeprom_store.sv
module seeprom_store #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     buf_clr_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  output logic                     busy_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] mask, mask_n;
  logic            busy, busy_n;
  logic [TW-1:0]   tmr, tmr_n;
  logic            wr_go;

  assign wr_go     = commit_i && (|mask) && !busy;
  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy;

  always_ff @(posedge clk) begin
    if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_go) begin
      for (int j = 0; j < PAGE; j++) begin
        if (mask[j]) mem[{page_i, PAGE_W'(j)}] <= pbuf[j];
      end
    end
  end

  always_comb begin
    mask_n = mask;
    busy_n = busy;
    tmr_n  = tmr;
    if (buf_clr_i || wr_go) begin
      mask_n = '0;
    end else if (buf_we_i) begin
      mask_n[buf_idx_i] = 1'b1;
    end
    if (wr_go) begin
      busy_n = 1'b1;
      tmr_n  = '0;
    end else if (busy) begin
      if (tmr == TW'(WR_CYCLES - 1)) busy_n = 1'b0;
      else                           tmr_n  = tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      busy <= 1'b0;
      tmr  <= '0;
    end else begin
      mask <= mask_n;
      busy <= busy_n;
      tmr  <= tmr_n;
    end
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tmr < TW'(WR_CYCLES))); // R6
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_i)); // R5

endmodule

// File: rtl/seeprom_proto.sv
module seeprom_proto
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bus_ev_t                  ev_i,
  input  logic                     scl_lvl_i,
  input  logic [2:0]               strap_i,
  input  logic                     wp_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_idx_o,
  output logic [7:0]               buf_data_o,
  output logic                     buf_clr_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic                     sda_pull_o
);

  link_st_e          st, st_n;
  rx_phase_e         ph, ph_n;
  logic [2:0]        cnt, cnt_n;
  logic              full, full_n;
  logic [7:0]        sreg, sreg_n;
  logic              rw, rw_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              pull, pull_n;
  logic              mack, mack_n;
  logic              dev_hit;

  assign dev_hit = (sreg[7:4] == DEV_TYPE) && (sreg[3:1] == strap_i) && !busy_i;

  always_comb begin
    st_n      = st;
    ph_n      = ph;
    cnt_n     = cnt;
    full_n    = full;
    sreg_n    = sreg;
    rw_n      = rw;
    addr_n    = addr;
    pull_n    = pull;
    mack_n    = mack;
    buf_we_o  = 1'b0;
    buf_clr_o = 1'b0;
    commit_o  = 1'b0;
    if (ev_i.start) begin
      st_n      = ST_RX;
      ph_n      = PH_DEV;
      cnt_n     = '0;
      full_n    = 1'b0;
      pull_n    = 1'b0;
      buf_clr_o = 1'b1;
    end else if (ev_i.stop) begin
      st_n     = ST_IDLE;
      full_n   = 1'b0;
      pull_n   = 1'b0;
      commit_o = 1'b1;
    end else begin
      case (st)
        ST_RX: begin
          if (ev_i.scl_rise) begin
            sreg_n = {sreg[6:0], ev_i.sda};
            cnt_n  = cnt + 3'd1;
            if (cnt == 3'd7) full_n = 1'b1;
          end else if (ev_i.scl_fall && full) begin
            full_n = 1'b0;
            cnt_n  = '0;
            case (ph)
              PH_DEV: begin
                if (dev_hit) begin
                  pull_n = 1'b1;
                  rw_n   = sreg[0];
                  st_n   = ST_ACK_OUT;
                end else begin
                  st_n = ST_IDLE;
                end
              end
              PH_ADDR: begin
                addr_n = sreg;
                pull_n = 1'b1;
                st_n   = ST_ACK_OUT;
              end
              default: begin
                pull_n   = 1'b1;
                st_n     = ST_ACK_OUT;
                buf_we_o = !wp_i;
                addr_n   = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
              end
            endcase
          end
        end
        ST_ACK_OUT: begin
          if (ev_i.scl_fall) begin
            cnt_n = '0;
            if (ph == PH_DEV && rw) begin
              st_n   = ST_TX;
              sreg_n = rd_data_i;
              pull_n = ~rd_data_i[7];
            end else begin
              pull_n = 1'b0;
              st_n   = ST_RX;
              ph_n   = (ph == PH_DEV) ? PH_ADDR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (ev_i.scl_rise) begin
            cnt_n = cnt + 3'd1;
            if (cnt == 3'd7) full_n = 1'b1;
          end else if (ev_i.scl_fall) begin
            if (full) begin
              full_n = 1'b0;
              pull_n = 1'b0;
              st_n   = ST_ACK_IN;
              addr_n = addr + ADDR_W'(1);
            end else begin
              sreg_n = {sreg[6:0], 1'b0};
              pull_n = ~sreg[6];
            end
          end
        end
        ST_ACK_IN: begin
          if (ev_i.scl_rise) begin
            mack_n = ~ev_i.sda;
          end else if (ev_i.scl_fall) begin
            if (mack) begin
              st_n   = ST_TX;
              sreg_n = rd_data_i;
              pull_n = ~rd_data_i[7];
              cnt_n  = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ph   <= PH_DEV;
      cnt  <= '0;
      full <= 1'b0;
      sreg <= '0;
      rw   <= 1'b0;
      addr <= '0;
      pull <= 1'b0;
      mack <= 1'b0;
    end else begin
      st   <= st_n;
      ph   <= ph_n;
      cnt  <= cnt_n;
      full <= full_n;
      sreg <= sreg_n;
      rw   <= rw_n;
      addr <= addr_n;
      pull <= pull_n;
      mack <= mack_n;
    end
  end

  assign rd_addr_o  = addr;
  assign buf_idx_o  = addr[PAGE_W-1:0];
  assign buf_data_o = sreg;
  assign page_o     = addr[ADDR_W-1:PAGE_W];
  assign sda_pull_o = pull;

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && ph == PH_DEV && full && ev_i.scl_fall && busy_i) |=> !sda_pull_o); // R6
  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && ph == PH_DEV && full && ev_i.scl_fall && sreg[3:1] != strap_i) |=> !sda_pull_o); // R2
  AST_DATA_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && ph == PH_DATA && full && ev_i.scl_fall) |=> sda_pull_o); // R7
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> (!$past(scl_lvl_i) || $past(ev_i.start) || $past(ev_i.stop))); // R11

endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       busy_o
);

  logic [1:0]               rst_sh;
  logic                     rst_ni;
  bus_ev_t                  ev;
  logic                     scl_lvl;
  logic [ADDR_W-1:0]        rd_addr;
  logic [7:0]               rd_data;
  logic                     buf_we, buf_clr, commit;
  logic [PAGE_W-1:0]        buf_idx;
  logic [7:0]               buf_data;
  logic [ADDR_W-PAGE_W-1:0] page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ni = rst_sh[1];

  seeprom_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk       (clk),
    .rst_n     (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .ev_o      (ev),
    .scl_lvl_o (scl_lvl)
  );

  seeprom_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk        (clk),
    .rst_n      (rst_ni),
    .ev_i       (ev),
    .scl_lvl_i  (scl_lvl),
    .strap_i    (strap_i),
    .wp_i       (wp_i),
    .busy_i     (busy_o),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .buf_we_o   (buf_we),
    .buf_idx_o  (buf_idx),
    .buf_data_o (buf_data),
    .buf_clr_o  (buf_clr),
    .commit_o   (commit),
    .page_o     (page),
    .sda_pull_o (sda_pull_o)
  );

  seeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk        (clk),
    .rst_n      (rst_ni),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .buf_we_i   (buf_we),
    .buf_idx_i  (buf_idx),
    .buf_data_i (buf_data),
    .buf_clr_i  (buf_clr),
    .commit_i   (commit),
    .page_i     (page),
    .busy_o     (busy_o)
  );

endmodule

// File: tb/seeprom_slave_tb.sv
module seeprom_slave_tb;

  localparam int WR = 300;
  localparam int Q  = 5;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull, busy;
  logic [2:0] strap = STRAP;
  wire  sda_line = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  int r11_viol = 0;
  int last_busy_len = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [32];
  logic [7:0] ptr = 8'h00;
  logic pull_q = 1'b0;

  always #10 clk = ~clk;

  seeprom_slave #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .wp_i(wp), .busy_o(busy)
  );

  // R11 monitor: the pull-down may change only while the master holds SCL low
  always @(negedge clk) begin
    if (rst_n && (pull_q !== sda_pull) && scl_m) r11_viol++;
    pull_q = sda_pull;
  end

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  function automatic logic [7:0] in_page(input logic [7:0] a, input int i);
    logic [3:0] lo;
    lo = a[3:0] + 4'(i);
    return {a[7:4], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!mack);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    last_busy_len = 0;
    while (busy && last_busy_len < 100000) begin @(negedge clk); last_busy_len++; end
    qw();
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic wpv);
    bit ack;
    wp = wpv;
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack);
    chk(ack, "R2 select write ack", ack, 1);
    send_byte(a, ack);
    chk(ack, "R3 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, wpv ? "R7 protected data ack" : "R3 data ack", ack, 1);
    end
    bus_stop();
    if (!wpv) begin
      for (int i = 0; i < n; i++) model[in_page(a, i)] = wbuf[i];
      wait_idle();
    end else begin
      repeat (4 * Q) @(negedge clk);
      chk(busy == 1'b0, "R7 no write window", busy, 0);
    end
    ptr = in_page(a, n);
    wp = 1'b0;
  endtask

  task automatic do_read(input bit sel, input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] v;
    bus_start();
    if (sel) begin
      send_byte(dev(STRAP, 1'b0), ack);
      chk(ack, "R8 select write ack", ack, 1);
      send_byte(a, ack);
      chk(ack, "R8 address ack", ack, 1);
      bus_start();
      ptr = a;
    end
    send_byte(dev(STRAP, 1'b1), ack);
    chk(ack, "R2 select read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(v === model[ptr], tag, v, model[ptr]);
      ptr = ptr + 8'd1;
    end
    bus_stop();
    qw();
  endtask

  task automatic finish_run();
    chk(r11_viol == 0, "R11 SDA change with SCL high", r11_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    do_read(1'b0, 8'h00, 2, "R1 current read after reset");
    do_read(1'b1, 8'h9C, 1, "R1 erased byte");

    // R2 wrong strap and wrong type are ignored for the whole transfer
    bus_start();
    send_byte(dev(3'b100, 1'b1), ack);
    chk(!ack, "R2 wrong strap nack", ack, 0);
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R2 silent after mismatch", v, 8'hFF);
    bus_stop(); qw();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack);
    chk(!ack, "R2 wrong type nack", ack, 0);
    bus_stop(); qw();

    // R3 byte write, R8 selective read, R6 window length
    wbuf[0] = 8'h5A;
    do_write(8'h42, 1, 1'b0);
    chk(last_busy_len == WR, "R6 write window length", last_busy_len, WR);
    do_read(1'b1, 8'h42, 1, "R8 selective read of byte write");

    // R6 select refused during the write window
    wbuf[0] = 8'hC3;
    wp = 1'b0;
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h10, ack);
    send_byte(wbuf[0], ack);
    bus_stop();
    model[8'h10] = 8'hC3;
    bus_start();
    send_byte(dev(STRAP, 1'b1), ack);
    chk(busy == 1'b1, "R6 busy during window", busy, 1);
    chk(!ack, "R6 nack while busy", ack, 0);
    bus_stop();
    wait_idle();
    ptr = 8'h11;
    do_read(1'b1, 8'h10, 1, "R6 data after window");

    // R4 page write from mid-page, wrapping inside page, 20 bytes
    for (int i = 0; i < 20; i++) wbuf[i] = 8'($urandom);
    do_write(8'h3B, 20, 1'b0);
    do_read(1'b1, 8'h30, 16, "R4 page wrap and overwrite");
    chk(model[8'h40] != wbuf[5] || model[8'h40] == 8'hFF, "R4 next page untouched", model[8'h40], 8'hFF);
    do_read(1'b1, 8'h40, 1, "R4 next page byte");

    // R7 write protect
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(8'h42, 3, 1'b1);
    do_read(1'b1, 8'h42, 3, "R7 array unchanged under protect");

    // R5 repeated START discards buffered bytes
    bus_start();
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h70, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_start();
    bus_stop();
    repeat (4 * Q) @(negedge clk);
    chk(busy == 1'b0, "R5 no window after discard", busy, 0);
    do_read(1'b1, 8'h70, 2, "R5 discarded bytes not stored");

    // R9 sequential wrap, R10 pointer after NACK
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    do_write(8'hFE, 2, 1'b0);
    wbuf[0] = 8'h03; wbuf[1] = 8'h04;
    do_write(8'h00, 2, 1'b0);
    do_read(1'b1, 8'hFD, 4, "R9 sequential read across FFh");
    do_read(1'b0, 8'h00, 1, "R10 current read after NACK");

    // constrained random mix
    for (int k = 0; k < 14; k++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      if ($urandom % 2 == 0) begin
        n = 1 + int'($urandom % 18);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(a, n, 1'b0);
      end else begin
        n = 1 + int'($urandom % 6);
        do_read(($urandom % 3) != 0, a, n, "R9 random read");
      end
    end
    do_read(1'b0, 8'h00, 2, "R10 current read random tail");

    finish_run();
  end

endmodule